// File: doc/BRIEF.md
# Receive Buffer Read-Status Indicator

This block drives one shared status pin that sits between a radio receive frame buffer and the serial read path of an SPI slave. Most of the time the pin carries the pending-interrupt flag. When byte-level flow control is enabled, it changes role once a frame-buffer burst read command has arrived inside a chip-select window. For the rest of that window it tells the host whether the next buffered byte can be clocked out (low) or has not yet been written by the receiver (high).

The block follows a write pointer that advances with each byte the receiver stores. It learns the buffer length from the first stored byte, the length header. A read pointer advances with each byte the host shifts during the burst. The status bytes appended after the payload are not held in the buffer, so they never count as missing. A receive error during the burst pins the output high until chip select is released. The switch into indicator mode waits a configurable number of clock cycles after the command byte is captured. This models the settling time the host must allow.

Top module: `rxbuf_status_pin`

## Requirements
- R1: While `mode_en` is low, `status_out` equals `irq_pending` at all times.
- R2: While `cs_n` is high, `status_out` equals `irq_pending`, and leaving the window at any point returns the pin to interrupt duty.
- R3: A burst is recognised only from the first byte received after `cs_n` falls, and only when `mode_en` is high and `(byte & 8'hE0) == 8'h20`. Any other first byte, and any later byte, leaves the pin carrying `irq_pending` for the whole window.
- R4: The capturing edge of the command byte is the first edge. `status_out` carries `irq_pending` until VALID_DLY further rising edges have passed, and shows the indicator from that point on.
- R5: In indicator mode, `status_out` is low when the number of bytes read in this burst is less than the number written. It is high when the read count has caught up with the write count inside the buffered region. `irq_pending` has no effect on either case.
- R6: A receiver write that makes the next byte available drives `status_out` low on the cycle after the write strobe.
- R7: The first stored byte sets the buffered length to `(byte & 8'h7F) + 1`. Once the read count reaches that length, the following trailer bytes keep `status_out` low.
- R8: A `rx_error` pulse during an open burst forces `status_out` high for the rest of that window, even when data or trailer bytes remain. Raising `cs_n` clears it. An `rx_error` pulse outside a burst has no effect on the next burst.
- R9: `rx_frame_start` resets the write count and the known length. Each recognised command resets the read count to zero.
- R10: Before any byte of the current frame is stored, the indicator reads empty (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Control bit that enables buffer-empty signalling |
| irq_pending | input | 1 | Pending-interrupt flag from the interrupt logic |
| cs_n | input | 1 | SPI chip select, active low |
| spi_byte_valid | input | 1 | One-cycle strobe: a full byte was exchanged on SPI |
| spi_byte | input | 8 | Byte received from the host with the strobe |
| rx_wr_stb | input | 1 | One-cycle strobe: receiver stored a byte in the buffer |
| rx_wr_data | input | 8 | Byte stored by the receiver |
| rx_frame_start | input | 1 | One-cycle strobe: a new received frame begins |
| rx_error | input | 1 | One-cycle strobe: receive error such as PLL unlock |
| status_out | output | 1 | Shared interrupt / buffer-empty pin |

## Verification
The assertions take the inputs to be one-cycle strobes. They also assume `rx_frame_start` never falls inside an open burst, and that the host keeps `cs_n` low from the command byte to the end of the burst. If these did not hold, the pointer relations the properties rely on could shift under a running burst. The bench drives every strobe for exactly one cycle at the falling clock edge and starts new frames only while chip select is high. It never writes more bytes than the announced length plus one. This keeps the stimulus inside those assumptions and still sweeps every written/read count pair for short frames.

// File: rtl/rxflag_pkg.sv
package rxflag_pkg;

    localparam int PTR_W = 8;
    localparam int LEN_W = 7;

    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_WAIT = 2'd1,
        BST_SHOW = 2'd2
    } burst_st_e;

    typedef struct packed {
        logic             len_known;
        logic [PTR_W-1:0] total;
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
    } ptr_view_t;

    function automatic logic is_burst_cmd(input logic [7:0] b,
                                          input logic [7:0] mask,
                                          input logic [7:0] code);
        return (b & mask) == code;
    endfunction

    function automatic logic [PTR_W-1:0] buffered_len(input logic [7:0] hdr);
        return PTR_W'(hdr[LEN_W-1:0]) + PTR_W'(1);
    endfunction

    function automatic logic in_trailer(input ptr_view_t v);
        return v.len_known && (v.rd_ptr >= v.total);
    endfunction

    function automatic logic next_missing(input ptr_view_t v);
        logic miss;
        if (!v.len_known) begin
            miss = 1'b1;
        end else if (in_trailer(v)) begin
            miss = 1'b0;
        end else begin
            miss = (v.rd_ptr >= v.wr_ptr);
        end
        return miss;
    endfunction

endpackage

// File: rtl/rxflag_cmd_detect.sv
module rxflag_cmd_detect
    import rxflag_pkg::*;
#(
    parameter int         VALID_DLY = 4,
    parameter logic [7:0] CMD_MASK  = 8'hE0,
    parameter logic [7:0] CMD_CODE  = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       mode_en,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       burst_begin,
    output logic       rd_adv,
    output logic       burst_open,
    output logic       burst_show
);

    localparam int CNT_W = (VALID_DLY > 1) ? $clog2(VALID_DLY) : 1;

    burst_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             first_seen_q;

    always_comb begin
        burst_begin = byte_valid && !cs_n && !first_seen_q && mode_en &&
                      is_burst_cmd(byte_in, CMD_MASK, CMD_CODE);
        rd_adv      = byte_valid && !cs_n && first_seen_q && (st_q != BST_IDLE);
        burst_open  = (st_q != BST_IDLE);
        burst_show  = (st_q == BST_SHOW);
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            st_q         <= BST_IDLE;
            cnt_q        <= '0;
            first_seen_q <= 1'b0;
        end else begin
            if (byte_valid) begin
                first_seen_q <= 1'b1;
            end
            case (st_q)
                BST_IDLE: begin
                    if (burst_begin) begin
                        if (VALID_DLY == 0) begin
                            st_q <= BST_SHOW;
                        end else begin
                            st_q  <= BST_WAIT;
                            cnt_q <= CNT_W'(VALID_DLY - 1);
                        end
                    end
                end
                BST_WAIT: begin
                    if (cnt_q == '0) begin
                        st_q <= BST_SHOW;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                BST_SHOW: begin
                    st_q <= BST_SHOW;
                end
                default: begin
                    st_q <= BST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/rxflag_ptr_track.sv
module rxflag_ptr_track
    import rxflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       burst_begin,
    input  logic       rd_adv,
    output ptr_view_t  view
);

    ptr_view_t v_q;

    assign view = v_q;

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            v_q.len_known <= 1'b0;
            v_q.total     <= '0;
            v_q.wr_ptr    <= '0;
        end else if (wr_stb) begin
            if (!v_q.len_known) begin
                v_q.len_known <= 1'b1;
                v_q.total     <= buffered_len(wr_data);
                v_q.wr_ptr    <= PTR_W'(1);
            end else if (v_q.wr_ptr < v_q.total) begin
                v_q.wr_ptr <= v_q.wr_ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || burst_begin) begin
            v_q.rd_ptr <= '0;
        end else if (rd_adv && (v_q.rd_ptr != '1)) begin
            v_q.rd_ptr <= v_q.rd_ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/rxflag_flag_mux.sv
module rxflag_flag_mux
    import rxflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      mode_en,
    input  logic      irq_pending,
    input  logic      rx_error,
    input  logic      burst_open,
    input  logic      burst_show,
    input  ptr_view_t view,
    output logic      err_lock,
    output logic      status_out
);

    logic err_q;
    logic indicator;

    assign err_lock = err_q;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            err_q <= 1'b0;
        end else if (burst_open && rx_error) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        indicator = err_q || next_missing(view);
        if (burst_show && !cs_n && mode_en) begin
            status_out = indicator;
        end else begin
            status_out = irq_pending;
        end
    end

endmodule

// File: rtl/rxbuf_status_pin.sv
module rxbuf_status_pin
    import rxflag_pkg::*;
#(
    parameter int         VALID_DLY = 4,
    parameter logic [7:0] CMD_MASK  = 8'hE0,
    parameter logic [7:0] CMD_CODE  = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_en,
    input  logic       irq_pending,
    input  logic       cs_n,
    input  logic       spi_byte_valid,
    input  logic [7:0] spi_byte,
    input  logic       rx_wr_stb,
    input  logic [7:0] rx_wr_data,
    input  logic       rx_frame_start,
    input  logic       rx_error,
    output logic       status_out
);

    logic      burst_begin;
    logic      rd_adv;
    logic      burst_open;
    logic      burst_show;
    logic      err_lock;
    ptr_view_t view;

    rxflag_cmd_detect #(
        .VALID_DLY (VALID_DLY),
        .CMD_MASK  (CMD_MASK),
        .CMD_CODE  (CMD_CODE)
    ) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .mode_en     (mode_en),
        .byte_valid  (spi_byte_valid),
        .byte_in     (spi_byte),
        .burst_begin (burst_begin),
        .rd_adv      (rd_adv),
        .burst_open  (burst_open),
        .burst_show  (burst_show)
    );

    rxflag_ptr_track u_ptr (
        .clk         (clk),
        .rst         (rst),
        .frame_start (rx_frame_start),
        .wr_stb      (rx_wr_stb),
        .wr_data     (rx_wr_data),
        .burst_begin (burst_begin),
        .rd_adv      (rd_adv),
        .view        (view)
    );

    rxflag_flag_mux u_mux (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .mode_en     (mode_en),
        .irq_pending (irq_pending),
        .rx_error    (rx_error),
        .burst_open  (burst_open),
        .burst_show  (burst_show),
        .view        (view),
        .err_lock    (err_lock),
        .status_out  (status_out)
    );

endmodule

// File: rtl/rxbuf_status_pin_checker.sv
module rxbuf_status_pin_checker
    import rxflag_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      mode_en,
    input logic      irq_pending,
    input logic      cs_n,
    input logic      rx_error,
    input logic      burst_open,
    input logic      burst_show,
    input logic      err_lock,
    input ptr_view_t view,
    input logic      status_out
);

    assert_mode_off_irq_R1: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> (status_out == irq_pending));

    assert_deselect_irq_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (status_out == irq_pending));

    assert_readable_low_R5: assert property (@(posedge clk) disable iff (rst)
        (burst_show && !cs_n && mode_en && !err_lock && view.len_known &&
         (view.rd_ptr < view.wr_ptr)) |-> !status_out);

    assert_trailer_low_R7: assert property (@(posedge clk) disable iff (rst)
        (burst_show && !cs_n && mode_en && !err_lock && view.len_known &&
         (view.rd_ptr >= view.total)) |-> !status_out);

    assert_error_latched_R8: assert property (@(posedge clk) disable iff (rst)
        (burst_open && rx_error && !cs_n) |=> err_lock);

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_lock && burst_show && !cs_n && mode_en) |-> status_out);

endmodule

bind rxbuf_status_pin rxbuf_status_pin_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_en     (mode_en),
    .irq_pending (irq_pending),
    .cs_n        (cs_n),
    .rx_error    (rx_error),
    .burst_open  (burst_open),
    .burst_show  (burst_show),
    .err_lock    (err_lock),
    .view        (view),
    .status_out  (status_out)
);

// File: tb/rxbuf_status_pin_bench.sv
`timescale 1ns/1ps
module rxbuf_status_pin_bench;

    localparam int DLY = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_en;
    logic       irq_pending;
    logic       cs_n;
    logic       spi_byte_valid;
    logic [7:0] spi_byte;
    logic       rx_wr_stb;
    logic [7:0] rx_wr_data;
    logic       rx_frame_start;
    logic       rx_error;
    logic       status_out;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rxbuf_status_pin #(.VALID_DLY(DLY)) u_rxbuf_status_pin (
        .clk            (clk),
        .rst            (rst),
        .mode_en        (mode_en),
        .irq_pending    (irq_pending),
        .cs_n           (cs_n),
        .spi_byte_valid (spi_byte_valid),
        .spi_byte       (spi_byte),
        .rx_wr_stb      (rx_wr_stb),
        .rx_wr_data     (rx_wr_data),
        .rx_frame_start (rx_frame_start),
        .rx_error       (rx_error),
        .status_out     (status_out)
    );

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (status_out !== exp) begin
            n_err++;
            $display("FAIL %s: status_out=%0b expected %0b", tag, status_out, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b);
        spi_byte_valid = 1'b1;
        spi_byte       = b;
        tick();
        spi_byte_valid = 1'b0;
    endtask

    task automatic store(input logic [7:0] b);
        rx_wr_stb  = 1'b1;
        rx_wr_data = b;
        tick();
        rx_wr_stb  = 1'b0;
    endtask

    task automatic new_frame();
        rx_frame_start = 1'b1;
        tick();
        rx_frame_start = 1'b0;
    endtask

    task automatic pulse_err();
        rx_error = 1'b1;
        tick();
        rx_error = 1'b0;
    endtask

    task automatic open_burst(input logic [7:0] cmd);
        cs_n = 1'b0;
        tick();
        send(cmd);
        repeat (DLY) tick();
    endtask

    task automatic close_burst();
        cs_n = 1'b1;
        tick();
    endtask

    function automatic logic exp_empty(input int len, input int w, input int r);
        if (w == 0) return 1'b1;
        if (r >= len + 1) return 1'b0;
        return (r >= w) ? 1'b1 : 1'b0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run hung, status_out=%0b expected completion", status_out);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_en = 1'b1; irq_pending = 1'b0; cs_n = 1'b1;
        spi_byte_valid = 1'b0; spi_byte = '0; rx_wr_stb = 1'b0; rx_wr_data = '0;
        rx_frame_start = 1'b0; rx_error = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // reset state follows the interrupt flag (R2)
        chk(1'b0, "R2 reset irq low");
        irq_pending = 1'b1; #1;
        chk(1'b1, "R2 reset irq high");
        irq_pending = 1'b0;

        // R4: settle delay, buffer empty (R10) so indicator is high
        new_frame();
        cs_n = 1'b0; tick();
        send(8'h20);
        repeat (DLY - 1) tick();
        chk(1'b0, "R4 before delay shows irq");
        tick();
        chk(1'b1, "R4 after delay shows indicator (R10 empty)");
        close_burst();
        chk(1'b0, "R2 after close");

        // R3: non-matching first byte, then matching later byte
        open_burst(8'h80);
        chk(1'b0, "R3 wrong opcode ignored");
        send(8'h20);
        repeat (DLY) tick();
        chk(1'b0, "R3 second byte not a command");
        close_burst();
        open_burst(8'h3F);
        chk(1'b1, "R3 masked opcode accepted");
        close_burst();

        // R1: mode disabled
        mode_en = 1'b0;
        open_burst(8'h20);
        chk(1'b0, "R1 mode off irq low");
        irq_pending = 1'b1; #1;
        chk(1'b1, "R1 mode off irq high");
        irq_pending = 1'b0;
        close_burst();
        mode_en = 1'b1;

        // R5 / R7 / R10: sweep written and read counts
        for (int len = 1; len <= 3; len++) begin
            for (int w = 0; w <= len + 1; w++) begin
                for (int r = 0; r <= len + 3; r++) begin
                    new_frame();
                    for (int k = 0; k < w; k++) store((k == 0) ? 8'(len) | 8'h80 : 8'(k));
                    irq_pending = r[0];
                    open_burst(8'h20);
                    for (int k = 0; k < r; k++) send(8'h00);
                    chk(exp_empty(len, w, r), (r >= len + 1 && w > 0) ? "R7 trailer" : "R5 sweep");
                    close_burst();
                    chk(r[0], "R2 sweep close");
                end
            end
        end
        irq_pending = 1'b0;

        // R6: receiver write during burst releases the host
        new_frame();
        store(8'h03);
        open_burst(8'h20);
        send(8'h00);
        chk(1'b1, "R6 waiting for byte");
        store(8'hAA);
        chk(1'b0, "R6 byte arrived");
        close_burst();

        // R9: read count restarts per command; frame start clears writes
        new_frame();
        store(8'h02); store(8'h11);
        open_burst(8'h20);
        send(8'h00); send(8'h00);
        chk(1'b1, "R9 caught up");
        close_burst();
        open_burst(8'h20);
        chk(1'b0, "R9 read count restarted");
        close_burst();
        new_frame();
        open_burst(8'h20);
        chk(1'b1, "R9 frame start cleared writes");
        close_burst();

        // R8: error lock
        new_frame();
        store(8'h03); store(8'h01); store(8'h02); store(8'h03);
        open_burst(8'h20);
        send(8'h00);
        chk(1'b0, "R8 before error");
        pulse_err();
        chk(1'b1, "R8 error forces empty");
        send(8'h00); send(8'h00); send(8'h00); send(8'h00);
        chk(1'b1, "R8 sticky into trailer");
        close_burst();
        chk(1'b0, "R8 released on close");
        open_burst(8'h20);
        chk(1'b0, "R8 cleared for next burst");
        close_burst();
        pulse_err();
        open_burst(8'h20);
        chk(1'b0, "R8 error outside burst ignored");
        close_burst();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule